// File: doc/BRIEF.md
# Triple-Bus Single-Cycle Datapath

This block is the execute core of a simple processor. A bank of 32 general registers, each 32 bits wide, feeds two operand buses. The first operand bus carries the register chosen by the first read address and the second carries the register chosen by the second read address. Both buses enter a combined arithmetic, shift and bitwise unit. That unit's result drives a single result bus, and the result bus is the only source of write data for the register bank.

Each clock cycle the surrounding controller presents a flat control word:

- two read addresses and one write address;
- a write enable;
- the compute-unit selection and its sub-controls.

The two reads and the compute settle during the cycle. The result is stored at the closing rising edge, so one operation completes per cycle. The result bus is brought out so that the operation in progress can be observed.

A controller with no immediate path can still build constants. It first produces all-ones with the bitwise unit, then derives other values with subtraction, addition and shifts.

Top module: `dp_triple_bus`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears all 32 registers to zero. Every read after reset returns 0x00000000 until the register is written.
- R2: With `alu_en`=1, `unit_sel`=00 and `sub`=0, `z_bus` equals operand A plus operand B, modulo 2^32.
- R3: With `alu_en`=1, `unit_sel`=00 and `sub`=1, `z_bus` equals A minus B, modulo 2^32.
- R4: With `alu_en`=1 and `unit_sel`=01, A is shifted by the amount in B[4:0]. The value of `shift_type` picks the shift:
  - 00: logical left;
  - 01: logical right;
  - 10: arithmetic right;
  - 11: rotate right.
- R5: With `alu_en`=1 and `unit_sel`=10, each bit i of `z_bus` equals `logic_fn[2*A[i]+B[i]]`. For example, 1000 gives AND, 1110 gives OR, 0110 gives XOR, 1100 passes A through and 1111 gives all-ones.
- R6: When `alu_en`=0, or when `unit_sel`=11, `z_bus` is zero. If `wr_en`=1 that zero is written to the destination.
- R7: When `wr_en`=0, no register changes at the edge.
- R8: A destination equal to a source uses the value held before the edge. With R1=1 and R2=3, R2 := R1 + R2 leaves R2=4.
- R9: Reads are combinational and do not forward a same-cycle write. A read in the cycle after a write returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_addr | input | 5 | Register read onto the A operand bus |
| y_addr | input | 5 | Register read onto the B operand bus |
| z_addr | input | 5 | Destination register for the result bus |
| wr_en | input | 1 | Store the result bus at the edge |
| alu_en | input | 1 | Enables the compute unit; when 0 the result is zero |
| unit_sel | input | 2 | 00 add/subtract, 01 shift, 10 bitwise, 11 none |
| sub | input | 1 | Selects subtraction in the add/subtract unit |
| shift_type | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| logic_fn | input | 4 | Truth table of the bitwise function, indexed by {A bit, B bit} |
| z_bus | output | 32 | Result bus value for the current cycle |

## Verification
The bench aims at the read-modify-write hazard, where destination and source coincide. A design that forwarded the new value, or wrote too early, would leave 5 or 6 instead of 4 in the R2 example.

It checks that a value written in one cycle appears on the next cycle's read, and that no write happens when the enable is low. A missing write, or a write into the wrong row, shows up as a stale value on a later read.

Shifts are driven with amounts 0, 3 and 31 and with negative operands. Swapped arithmetic/logical right shifts, or a rotate that drops bits, give wrong sign bits or wrong wrap bits.

Disabled and reserved unit selections are run together with a live write enable. A design that left the previous result on the bus would store a nonzero value where zero is expected.

// File: rtl/dp_pkg.sv
// Shared encodings for the triple-bus datapath.
// Assumes the control word fields are decoded exactly as listed here.
package dp_pkg;
    typedef enum logic [1:0] {
        UNIT_ARITH = 2'b00,
        UNIT_SHIFT = 2'b01,
        UNIT_LOGIC = 2'b10,
        UNIT_NONE  = 2'b11
    } unit_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_e;
endpackage

// File: rtl/dp_regfile.sv
// Register bank with two combinational read ports and one synchronous write port.
// Assumes a synchronous active-low reset that clears every row; reads never forward the write.
module dp_regfile #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_x_addr,
    input  logic [ADDR_W-1:0] rd_y_addr,
    output logic [DATA_W-1:0] rd_x,
    output logic [DATA_W-1:0] rd_y,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] rows [DEPTH];

    // Clear on reset, otherwise store the write data at the addressed row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) rows[i] <= '0;
        end else if (wr_en) begin
            rows[wr_addr] <= wr_data;
        end
    end

    // Combinational read ports that reflect the contents held before the edge.
    always_comb begin
        rd_x = rows[rd_x_addr];
        rd_y = rows[rd_y_addr];
    end

    // A read in the cycle right after reset sees a cleared row.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_x == '0);

    // A write becomes visible on the read in the following cycle.
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && rd_x_addr == $past(wr_addr))
        |-> rd_x == $past(wr_data));

    // Without a write enable the row under read keeps its value.
    assert_no_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && rd_x_addr == $past(rd_x_addr))
        |-> rd_x == $past(rd_x));
endmodule

// File: rtl/dp_alu.sv
// Combined add/subtract, shift and bitwise unit driving the result bus.
// Assumes the shift amount is the low bits of operand B; an idle or reserved selection yields zero.
module dp_alu
    import dp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              enable,
    input  unit_e             unit,
    input  logic              sub,
    input  shift_e            shift_type,
    input  logic [3:0]        logic_fn,
    output logic [DATA_W-1:0] result
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0]   arith_res;
    logic [DATA_W-1:0]   shift_res;
    logic [DATA_W-1:0]   logic_res;
    logic [SH_W-1:0]     amount;
    logic [2*DATA_W-1:0] rot_wide;

    // Adder/subtractor: a two's-complement adder on a conditionally inverted operand.
    always_comb begin
        arith_res = op_a + (sub ? ~op_b : op_b) + {{(DATA_W-1){1'b0}}, sub};
    end

    // Shifter: the amount comes from the low bits of operand B.
    always_comb begin
        amount   = op_b[SH_W-1:0];
        rot_wide = {op_a, op_a} >> amount;
        unique case (shift_type)
            SH_LSL:  shift_res = op_a << amount;
            SH_LSR:  shift_res = op_a >> amount;
            SH_ASR:  shift_res = DATA_W'($signed(op_a) >>> amount);
            default: shift_res = rot_wide[DATA_W-1:0];
        endcase
    end

    // Bitwise unit: each bit looks up its own pair of operand bits in the truth table.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lut
        assign logic_res[i] = logic_fn[{op_a[i], op_b[i]}];
    end

    // Result mux: zero when disabled or when no unit is selected.
    always_comb begin
        result = '0;
        if (enable) begin
            unique case (unit)
                UNIT_ARITH: result = arith_res;
                UNIT_SHIFT: result = shift_res;
                UNIT_LOGIC: result = logic_res;
                default:    result = '0;
            endcase
        end
    end
endmodule

// File: rtl/dp_triple_bus.sv
// Single-cycle datapath: the register bank drives the A and B buses, the compute unit drives
// the result bus, and the result is written back at the closing edge.
// Assumes a fresh control word each cycle and a synchronous active-low reset.
module dp_triple_bus
    import dp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [ADDR_W-1:0] y_addr,
    input  logic [ADDR_W-1:0] z_addr,
    input  logic              wr_en,
    input  logic              alu_en,
    input  logic [1:0]        unit_sel,
    input  logic              sub,
    input  logic [1:0]        shift_type,
    input  logic [3:0]        logic_fn,
    output logic [DATA_W-1:0] z_bus
);
    logic [DATA_W-1:0] x_bus;
    logic [DATA_W-1:0] y_bus;

    dp_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_x_addr (x_addr),
        .rd_y_addr (y_addr),
        .rd_x      (x_bus),
        .rd_y      (y_bus),
        .wr_en     (wr_en),
        .wr_addr   (z_addr),
        .wr_data   (z_bus)
    );

    dp_alu #(.DATA_W(DATA_W)) u_alu (
        .op_a       (x_bus),
        .op_b       (y_bus),
        .enable     (alu_en),
        .unit       (unit_e'(unit_sel)),
        .sub        (sub),
        .shift_type (shift_e'(shift_type)),
        .logic_fn   (logic_fn),
        .result     (z_bus)
    );

    // A disabled unit or the reserved selection puts zero on the result bus.
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!alu_en || unit_sel == 2'b11) |-> z_bus == '0);

    // Truth table 1100 passes operand A unchanged.
    assert_pass_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_en && unit_sel == 2'b10 && logic_fn == 4'b1100) |-> z_bus == x_bus);

    // A shift by zero leaves operand A unchanged, whatever the shift type.
    assert_shift_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_en && unit_sel == 2'b01 && y_bus[4:0] == 5'd0) |-> z_bus == x_bus);

    // Subtracting a register from itself gives zero.
    assert_sub_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_en && unit_sel == 2'b00 && sub && x_addr == y_addr) |-> z_bus == '0);
endmodule

// File: tb/tb_dp_triple_bus.sv
`timescale 1ns/1ps
module tb_dp_triple_bus;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  x_addr = '0, y_addr = '0, z_addr = '0;
    logic        wr_en = 1'b0, alu_en = 1'b0, sub = 1'b0;
    logic [1:0]  unit_sel = '0, shift_type = '0;
    logic [3:0]  logic_fn = '0;
    logic [31:0] z_bus;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] model [32];

    always #2.5 clk = ~clk;

    dp_triple_bus dut (
        .clk(clk), .rst_n(rst_n), .x_addr(x_addr), .y_addr(y_addr), .z_addr(z_addr),
        .wr_en(wr_en), .alu_en(alu_en), .unit_sel(unit_sel), .sub(sub),
        .shift_type(shift_type), .logic_fn(logic_fn), .z_bus(z_bus)
    );

    // Behavioural reference for the result bus.
    function automatic logic [31:0] ref_z(logic [31:0] a, logic [31:0] b, bit en,
                                          logic [1:0] us, bit sb, logic [1:0] st,
                                          logic [3:0] lf);
        int amt;
        logic [31:0] r;
        amt = int'(b[4:0]);
        if (!en) return 32'h0;
        case (us)
            2'd0: return sb ? a - b : a + b;
            2'd1: begin
                case (st)
                    2'd0: return a << amt;
                    2'd1: return a >> amt;
                    2'd2: return 32'($signed(a) >>> amt);
                    default: return (a >> amt) | (a << (32 - amt));
                endcase
            end
            2'd2: begin
                for (int i = 0; i < 32; i++) r[i] = lf[2 * int'(a[i]) + int'(b[i])];
                return r;
            end
            default: return 32'h0;
        endcase
    endfunction

    // Drive one control word, compare the result bus, then advance the model at the edge.
    task automatic step(input bit rst, input logic [4:0] xa, input logic [4:0] ya,
                        input logic [4:0] za, input bit we, input bit en,
                        input logic [1:0] us, input bit sb, input logic [1:0] st,
                        input logic [3:0] lf, input string tag,
                        input logic [31:0] want_override = 32'hx, input bit use_override = 1'b0);
        logic [31:0] exp;
        rst_n = rst; x_addr = xa; y_addr = ya; z_addr = za; wr_en = we;
        alu_en = en; unit_sel = us; sub = sb; shift_type = st; logic_fn = lf;
        #1;
        exp = ref_z(model[xa], model[ya], en, us, sb, st, lf);
        if (use_override) exp = want_override;
        n_checks++;
        if (z_bus !== exp) begin
            n_fail++;
            $display("FAIL %s: z_bus actual %h expected %h (x=%0d y=%0d z=%0d)",
                     tag, z_bus, exp, xa, ya, za);
        end
        @(posedge clk);
        if (!rst) begin
            for (int i = 0; i < 32; i++) model[i] = 32'h0;
        end else if (we) begin
            model[za] = exp;
        end
        @(negedge clk);
    endtask

    // Read register r onto the result bus through the pass-A truth table, without writing.
    task automatic rd(input logic [4:0] r, input logic [31:0] want, input string tag);
        step(1'b1, r, 5'd0, 5'd0, 1'b0, 1'b1, 2'b10, 1'b0, 2'b00, 4'b1100, tag, want, 1'b1);
    endtask

    initial begin
        // Reset held over two edges.
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 32; i++) model[i] = 32'h0;
        @(negedge clk);

        // R1: every register reads zero after reset.
        for (int i = 0; i < 32; i++) rd(5'(i), 32'h0, "R1");

        // R5: all-ones from truth table 1111 into R31.
        step(1, 5'd0, 5'd0, 5'd31, 1, 1, 2'b10, 0, 2'b00, 4'b1111, "R5");
        rd(5'd31, 32'hFFFF_FFFF, "R9");
        // R3: R1 = 0 - all-ones = 1.
        step(1, 5'd0, 5'd31, 5'd1, 1, 1, 2'b00, 1, 2'b00, 4'b0000, "R3");
        rd(5'd1, 32'h1, "R3");
        // R2: R2 = 1+1, R3 = R2+R1.
        step(1, 5'd1, 5'd1, 5'd2, 1, 1, 2'b00, 0, 2'b00, 4'b0000, "R2");
        step(1, 5'd2, 5'd1, 5'd3, 1, 1, 2'b00, 0, 2'b00, 4'b0000, "R2");
        rd(5'd3, 32'h3, "R2");
        // R8: R2 = 3, then R2 := R1 + R2 gives 4.
        step(1, 5'd3, 5'd0, 5'd2, 1, 1, 2'b10, 0, 2'b00, 4'b1100, "R5");
        step(1, 5'd1, 5'd2, 5'd2, 1, 1, 2'b00, 0, 2'b00, 4'b0000, "R8", 32'h4, 1'b1);
        rd(5'd2, 32'h4, "R8");
        // R7: no write with the enable low.
        step(1, 5'd31, 5'd0, 5'd5, 0, 1, 2'b10, 0, 2'b00, 4'b1100, "R7");
        rd(5'd5, 32'h0, "R7");
        // R4: shift corners, amount taken from R3 = 3 and R1 = 1.
        step(1, 5'd1, 5'd3, 5'd15, 1, 1, 2'b01, 0, 2'b00, 4'b0000, "R4", 32'h8, 1'b1);
        rd(5'd15, 32'h8, "R4");
        step(1, 5'd31, 5'd3, 5'd16, 1, 1, 2'b01, 0, 2'b01, 4'b0000, "R4", 32'h1FFF_FFFF, 1'b1);
        step(1, 5'd31, 5'd3, 5'd17, 1, 1, 2'b01, 0, 2'b10, 4'b0000, "R4", 32'hFFFF_FFFF, 1'b1);
        step(1, 5'd1, 5'd1, 5'd18, 1, 1, 2'b01, 0, 2'b11, 4'b0000, "R4", 32'h8000_0000, 1'b1);
        step(1, 5'd18, 5'd31, 5'd19, 1, 1, 2'b01, 0, 2'b10, 4'b0000, "R4", 32'hFFFF_FFFF, 1'b1);
        step(1, 5'd18, 5'd31, 5'd20, 1, 1, 2'b01, 0, 2'b01, 4'b0000, "R4", 32'h1, 1'b1);
        step(1, 5'd3, 5'd0, 5'd21, 1, 1, 2'b01, 0, 2'b11, 4'b0000, "R4", 32'h3, 1'b1);
        rd(5'd18, 32'h8000_0000, "R4");
        // R5: XOR of 3 and 1 gives 2.
        step(1, 5'd3, 5'd1, 5'd22, 1, 1, 2'b10, 0, 2'b00, 4'b0110, "R5", 32'h2, 1'b1);
        // R6: disabled unit and reserved selection write zero.
        step(1, 5'd31, 5'd31, 5'd31, 1, 0, 2'b10, 0, 2'b00, 4'b1111, "R6", 32'h0, 1'b1);
        rd(5'd31, 32'h0, "R6");
        step(1, 5'd3, 5'd3, 5'd3, 1, 1, 2'b11, 0, 2'b00, 4'b1111, "R6", 32'h0, 1'b1);
        rd(5'd3, 32'h0, "R6");

        // Random control words compared against the model every cycle.
        for (int k = 0; k < 3000; k++) begin
            bit rs, we, en, sb;
            logic [1:0] us, st;
            string tag;
            rs = ($urandom_range(0, 299) != 0);
            we = ($urandom_range(0, 3) != 0);
            en = ($urandom_range(0, 7) != 0);
            us = 2'($urandom);
            sb = 1'($urandom);
            st = 2'($urandom);
            if (!en || us == 2'b11) tag = "R6";
            else if (us == 2'b00) tag = sb ? "R3" : "R2";
            else if (us == 2'b01) tag = "R4";
            else tag = "R5";
            if (!rs) tag = "R1";
            step(rs, 5'($urandom), 5'($urandom), 5'($urandom), we, en, us, sb, st,
                 4'($urandom), tag);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule